// File: doc/BRIEF.md
# Mode-Register SDRAM Command Issuer

This block sits in front of a low-power DDR SDRAM controller. It turns host writes into device commands during the power-up sequence. Software first stores a mode value in a control register. While that value is non-zero, each host write to the memory window is taken over: no data is written, and the block drives exactly one SDRAM command of the selected kind on a small command/bank/address pin bundle. The available commands are no-operation, precharge of all banks, auto-refresh, mode register load and extended mode register load.

Software steps through the initialization itself. It writes a mode, then makes a dummy memory write, and repeats. For the two mode-register loads, the bank bits and the value sent on the address pins come from the host address of the triggering write. The device clock enable stays low until the first no-operation command is issued. After software returns the mode to zero, one further host write finishes the switch to normal operation. From then on, host writes produce data-write strobes, and a refresh interval timer raises a refresh request every programmed number of cycles. That request stays pending until the controller accepts it.

Each host write gets a one-cycle ready pulse. The pulse comes after the command cycle and after a programmable extra gap that enforces the command-to-command spacing.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: The control register selected by reg_sel=0 takes its mode from reg_wdata[2:0] with the codes 0=normal, 1=no-operation, 2=precharge all, 3=mode register load, 4=auto-refresh and 5=extended mode register load. A write of 6 or 7 leaves the stored mode unchanged. reg_sel=1 loads the refresh count and reg_sel=2 loads the gap.
- R2: In a non-zero mode, each accepted host write drives exactly one command, for exactly one cycle, in the cycle after the write is sampled, and data_wr_en stays low. The pins {ras_n,cas_n,we_n} are 111 for no-operation (also the idle value), 010 for precharge, 001 for auto-refresh and 000 for both mode register loads.
- R3: mem_cke is low from reset. It rises in the same cycle as the first no-operation command, and never falls afterwards. Other commands do not raise it.
- R4: While the mode is 4, every host write issues its own auto-refresh command, so two writes give two commands.
- R5: For both mode register loads, cmd_ba equals host address bits [23:22] and cmd_addr equals host address bits [13:1].
- R6: A precharge command drives cmd_addr with only bit 10 set and cmd_ba at 0. No-operation and auto-refresh drive cmd_addr and cmd_ba at 0.
- R7: The host write sampled at clock edge k is acknowledged by a one-cycle mem_ready pulse that rises at edge k+1+gap. A host write that arrives before that pulse is ignored.
- R8: After reset, or after the mode has held a non-zero value, the first host write made in mode 0 produces neither a command nor a data strobe. Every later write in mode 0 produces a one-cycle data_wr_en in place of a command.
- R9: Once normal operation is complete (R8), ref_req is raised every N cycles, where N is the refresh count, and the first raise comes N edges after the completing write is sampled. The timer does not run in a non-zero mode or before completion, and a count of 0 disables it.
- R10: ref_req stays high until ref_ack is sampled, whatever the number of periods that pass. One acknowledge clears it, so at most one request is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 refresh count, 2 gap |
| reg_wdata | input | 16 | Register write data |
| mem_wr | input | 1 | Host write strobe to the memory window |
| mem_addr | input | 32 | Host byte address of that write |
| mem_ready | output | 1 | One-cycle acknowledge of a host write |
| data_wr_en | output | 1 | One-cycle data write strobe in normal operation |
| mem_cke | output | 1 | Device clock enable |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 13 | Device address pins |
| ref_req | output | 1 | Pending refresh request |
| ref_ack | input | 1 | Refresh request accepted |

## Verification
The bench builds the block with its default parameters: a 32-bit host address, the bank field at bits [23:22], a 13-bit device address taken from bits [13:1], a 16-bit refresh count and a 4-bit gap. The gap width keeps the ready delay to a few cycles, which lets the bench sweep every command mode against gaps 0 to 3 and against four bank values with varied address patterns. It also fires a stray host write inside each busy window. A refresh count of 6 makes several timer periods, the request hold across missed periods, and the stop outside normal mode all fit within a few dozen cycles.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_AREF   = 3'd4,
    MODE_XLMR   = 3'd5
  } mode_e;

  localparam logic [2:0] MODE_LAST = 3'd5;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pins_t PINS_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam pins_t PINS_AREF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pins_t PINS_LMR  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_REFCNT = 2'd1;
  localparam logic [1:0] SEL_GAP    = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  function automatic pins_t pins_of(input mode_e m);
    case (m)
      MODE_PALL: pins_of = PINS_PALL;
      MODE_AREF: pins_of = PINS_AREF;
      MODE_LMR,
      MODE_XLMR: pins_of = PINS_LMR;
      default:   pins_of = PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/cmdiss_regs.sv
module cmdiss_regs
  import sdram_cmd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REFCNT_W = 16,
  parameter int GAP_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [DATA_W-1:0]   reg_wdata,
  output mode_e               mode,
  output logic [REFCNT_W-1:0] refcnt,
  output logic [GAP_W-1:0]    gap
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_NORMAL;
      refcnt <= '0;
      gap    <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_MODE: begin
          if (reg_wdata[2:0] <= MODE_LAST)
            mode <= mode_e'(reg_wdata[2:0]);
        end
        SEL_REFCNT: refcnt <= reg_wdata[REFCNT_W-1:0];
        SEL_GAP:    gap    <= reg_wdata[GAP_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmdiss_seq.sv
module cmdiss_seq
  import sdram_cmd_pkg::*;
#(
  parameter int HADDR_W = 32,
  parameter int BA_LO   = 22,
  parameter int BA_W    = 2,
  parameter int A_LO    = 1,
  parameter int A_W     = 13,
  parameter int AP_BIT  = 10,
  parameter int GAP_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_e              mode,
  input  logic [GAP_W-1:0]   gap,
  input  logic               mem_wr,
  input  logic [HADDR_W-1:0] mem_addr,
  output logic               mem_ready,
  output logic               data_wr_en,
  output logic               mem_cke,
  output pins_t              pins,
  output logic [BA_W-1:0]    ba,
  output logic [A_W-1:0]     addr,
  output logic               in_normal
);

  seq_state_e           state;
  logic [GAP_W-1:0]     cnt;
  logic [A_W-1:0]       pall_addr;
  logic                 accept;

  for (genvar i = 0; i < A_W; i++) begin : g_pall
    assign pall_addr[i] = (i == AP_BIT);
  end

  assign accept = (state == ST_IDLE) && mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      mem_ready  <= 1'b0;
      data_wr_en <= 1'b0;
      mem_cke    <= 1'b0;
      pins       <= PINS_NOP;
      ba         <= '0;
      addr       <= '0;
      in_normal  <= 1'b0;
    end else begin
      mem_ready  <= 1'b0;
      data_wr_en <= 1'b0;
      pins       <= PINS_NOP;
      ba         <= '0;
      addr       <= '0;
      if (mode != MODE_NORMAL) in_normal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_ISSUE;
            case (mode)
              MODE_NORMAL: begin
                if (in_normal) data_wr_en <= 1'b1;
                else           in_normal  <= 1'b1;
              end
              MODE_NOP: begin
                pins    <= PINS_NOP;
                mem_cke <= 1'b1;
              end
              MODE_PALL: begin
                pins <= PINS_PALL;
                addr <= pall_addr;
              end
              MODE_LMR, MODE_XLMR: begin
                pins <= PINS_LMR;
                ba   <= mem_addr[BA_LO +: BA_W];
                addr <= mem_addr[A_LO +: A_W];
              end
              default: pins <= pins_of(mode);
            endcase
          end
        end
        ST_ISSUE: begin
          if (gap == '0) begin
            mem_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt   <= gap - 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            mem_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdiss_refresh.sv
module cmdiss_refresh #(
  parameter int REFCNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [REFCNT_W-1:0] refcnt,
  input  logic                ref_ack,
  output logic                ref_req
);

  logic [REFCNT_W-1:0] tmr;
  logic                expire;

  assign expire = run && (refcnt != '0) && (tmr <= 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      ref_req <= 1'b0;
    end else begin
      if (!run || expire) tmr <= refcnt;
      else                tmr <= tmr - 1'b1;
      ref_req <= (ref_req && !ref_ack) || expire;
    end
  end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int HADDR_W  = 32,
  parameter int DATA_W   = 16,
  parameter int BA_LO    = 22,
  parameter int BA_W     = 2,
  parameter int A_LO     = 1,
  parameter int A_W      = 13,
  parameter int AP_BIT   = 10,
  parameter int REFCNT_W = 16,
  parameter int GAP_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               mem_wr,
  input  logic [HADDR_W-1:0] mem_addr,
  output logic               mem_ready,
  output logic               data_wr_en,
  output logic               mem_cke,
  output logic               cmd_ras_n,
  output logic               cmd_cas_n,
  output logic               cmd_we_n,
  output logic [BA_W-1:0]    cmd_ba,
  output logic [A_W-1:0]     cmd_addr,
  output logic               ref_req,
  input  logic               ref_ack
);

  mode_e               mode;
  logic [REFCNT_W-1:0] refcnt;
  logic [GAP_W-1:0]    gap;
  pins_t               pins;
  logic                in_normal;
  logic                run;

  cmdiss_regs #(
    .DATA_W(DATA_W), .REFCNT_W(REFCNT_W), .GAP_W(GAP_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mode(mode), .refcnt(refcnt), .gap(gap)
  );

  cmdiss_seq #(
    .HADDR_W(HADDR_W), .BA_LO(BA_LO), .BA_W(BA_W), .A_LO(A_LO),
    .A_W(A_W), .AP_BIT(AP_BIT), .GAP_W(GAP_W)
  ) u_seq (
    .clk(clk), .rst(rst), .mode(mode), .gap(gap), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .data_wr_en(data_wr_en),
    .mem_cke(mem_cke), .pins(pins), .ba(cmd_ba), .addr(cmd_addr),
    .in_normal(in_normal)
  );

  assign run = in_normal && (mode == MODE_NORMAL);

  cmdiss_refresh #(
    .REFCNT_W(REFCNT_W)
  ) u_ref (
    .clk(clk), .rst(rst), .run(run), .refcnt(refcnt),
    .ref_ack(ref_ack), .ref_req(ref_req)
  );

  assign cmd_ras_n = pins.ras_n;
  assign cmd_cas_n = pins.cas_n;
  assign cmd_we_n  = pins.we_n;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk #(
  parameter int A_W    = 13,
  parameter int AP_BIT = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_ready,
  input logic           data_wr_en,
  input logic           mem_cke,
  input logic           cmd_ras_n,
  input logic           cmd_cas_n,
  input logic           cmd_we_n,
  input logic [A_W-1:0] cmd_addr,
  input logic           ref_req,
  input logic           ref_ack
);

  logic idle_pins;
  assign idle_pins = cmd_ras_n && cmd_cas_n && cmd_we_n;

  assert_cmd_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    !idle_pins |=> idle_pins);

  assert_no_data_with_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    data_wr_en |-> idle_pins);

  assert_cke_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    mem_cke |=> mem_cke);

  assert_pall_autoprecharge_R6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ras_n && cmd_cas_n && !cmd_we_n) |-> cmd_addr[AP_BIT]);

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    mem_ready |=> !mem_ready);

  assert_data_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    data_wr_en |=> !data_wr_en);

  assert_ref_held_R10: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> ref_req);

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(
  .A_W(A_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .mem_ready(mem_ready), .data_wr_en(data_wr_en),
  .mem_cke(mem_cke), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
  .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr), .ref_req(ref_req),
  .ref_ack(ref_ack)
);

// File: tb/tb_sdram_cmd_issuer.sv
module tb_sdram_cmd_issuer;

  localparam int BA_LO = 22;
  localparam int A_LO  = 1;
  localparam int AP    = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        mem_wr = 1'b0;
  logic [31:0] mem_addr = 32'd0;
  logic        mem_ready, data_wr_en, mem_cke;
  logic        cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr;
  logic        ref_req;
  logic        ref_ack = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_issuer dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .data_wr_en(data_wr_en), .mem_cke(mem_cke),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .ref_req(ref_req),
    .ref_ack(ref_ack)
  );

  int  vecs = 0;
  int  miss = 0;
  int  cyc = 0;
  int  last_k = 0;
  bit  cke_model = 1'b0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  // expected {ras,cas,we,ba[1:0],addr[12:0]}
  function automatic logic [17:0] exp_bus(input int m, input logic [31:0] a);
    case (m)
      2:       exp_bus = {3'b010, 2'b00, 13'(1 << AP)};
      3, 5:    exp_bus = {3'b000, a[BA_LO +: 2], a[A_LO +: 13]};
      4:       exp_bus = {3'b001, 2'b00, 13'd0};
      default: exp_bus = {3'b111, 2'b00, 13'd0};
    endcase
  endfunction

  task automatic reg_write(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic host_write(input logic [31:0] a, input int m,
                            input bit norm_active, input int g, input bit inject);
    int ncmd;
    int ready_at;
    logic [17:0] bus, expv;
    ncmd = 0;
    ready_at = -1;
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = a;
    @(negedge clk);
    mem_wr = 1'b0;
    last_k = cyc;
    if (m == 1) cke_model = 1'b1;
    bus  = {cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_ba, cmd_addr};
    expv = exp_bus(m, a);
    check(bus == expv, (m == 3 || m == 5) ? "R5" : (m == 2 ? "R6" : "R2"),
          "command bus", bus, expv);
    check(data_wr_en == (m == 0 && norm_active), "R8", "data strobe",
          data_wr_en, (m == 0 && norm_active));
    check(mem_cke == cke_model, "R3", "clock enable", mem_cke, cke_model);
    check(mem_ready == 1'b0, "R7", "ready during command", mem_ready, 0);
    for (int idx = 2; idx < 40; idx++) begin
      @(negedge clk);
      if (inject && idx == 2) mem_wr = 1'b1;
      if (idx == 3) mem_wr = 1'b0;
      if (!(cmd_ras_n && cmd_cas_n && cmd_we_n) || data_wr_en) ncmd++;
      if (mem_ready) begin
        ready_at = idx;
        break;
      end
    end
    mem_wr = 1'b0;
    check(ncmd == 0, "R2", "extra activity after command", ncmd, 0);
    check(ready_at == 2 + g, "R7", "ready position", ready_at, 2 + g);
  endtask

  initial begin
    logic [31:0] a;
    int kk;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_cke == 1'b0, "R3", "cke after reset", mem_cke, 0);
    check({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b111, "R2", "idle pins",
          {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b111);
    check(mem_ready == 1'b0, "R7", "ready after reset", mem_ready, 0);
    check(ref_req == 1'b0, "R10", "ref_req after reset", ref_req, 0);
    check(data_wr_en == 1'b0, "R8", "data after reset", data_wr_en, 0);

    // R3: precharge before any NOP leaves the clock off, NOP turns it on
    reg_write(2'd2, 16'd0);
    reg_write(2'd0, 16'd2);
    host_write(32'h0040_0000, 2, 1'b0, 0, 1'b0);
    reg_write(2'd0, 16'd1);
    host_write(32'h0000_0000, 1, 1'b0, 0, 1'b0);

    // sweep over gap, mode and bank pattern
    for (int g = 0; g < 4; g++) begin
      reg_write(2'd2, 16'(g));
      for (int m = 1; m <= 5; m++) begin
        reg_write(2'd0, 16'(m));
        for (int ai = 0; ai < 4; ai++) begin
          a = (32'(ai) << BA_LO)
            | (32'((13'h1A5 ^ 13'(ai * 37 + m * 11 + g * 5)) & 13'h1FFF) << A_LO)
            | (32'(ai * 3 + m) << 14) | 32'(ai & 1);
          // R4: every write in mode 4 gives its own auto-refresh command
          host_write(a, m, 1'b0, g, (g >= 1) && (ai == 1));
        end
      end
    end

    // R1: reserved mode values are not stored
    reg_write(2'd2, 16'd1);
    reg_write(2'd0, 16'd3);
    reg_write(2'd0, 16'd6);
    host_write(32'h00C0_2468, 3, 1'b0, 1, 1'b0);
    reg_write(2'd0, 16'd7);
    host_write(32'h0080_1357, 3, 1'b0, 1, 1'b0);
    reg_write(2'd0, 16'd4);
    reg_write(2'd0, 16'd6);
    host_write(32'h0000_0010, 4, 1'b0, 1, 1'b0);

    // R8: completion write, then data writes
    reg_write(2'd2, 16'd0);
    reg_write(2'd0, 16'd0);
    host_write(32'h0000_0100, 0, 1'b0, 0, 1'b0);
    host_write(32'h0000_0200, 0, 1'b1, 0, 1'b0);
    host_write(32'h0000_0300, 0, 1'b1, 0, 1'b0);
    reg_write(2'd0, 16'd1);
    host_write(32'h0000_0000, 1, 1'b0, 0, 1'b0);
    reg_write(2'd0, 16'd0);
    host_write(32'h0000_0400, 0, 1'b0, 0, 1'b0);
    host_write(32'h0000_0500, 0, 1'b1, 0, 1'b0);

    // R9 and R10: refresh timer with N = 6
    reg_write(2'd1, 16'd6);
    reg_write(2'd0, 16'd1);
    reg_write(2'd0, 16'd0);
    host_write(32'h0000_0000, 0, 1'b0, 0, 1'b0);
    kk = last_k;
    while (cyc < kk + 6) begin
      check(ref_req == 1'b0, "R9", "ref_req before first period", ref_req, 0);
      @(negedge clk);
    end
    check(ref_req == 1'b1, "R9", "first refresh request", ref_req, 1);
    while (cyc < kk + 21) begin
      @(negedge clk);
      check(ref_req == 1'b1, "R10", "request held without ack", ref_req, 1);
    end
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    check(ref_req == 1'b0, "R10", "single ack clears request", ref_req, 0);
    while (cyc < kk + 24) @(negedge clk);
    check(ref_req == 1'b1, "R9", "request at 4N", ref_req, 1);
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    check(ref_req == 1'b0, "R10", "ack clears at 4N+1", ref_req, 0);
    while (cyc < kk + 29) begin
      @(negedge clk);
      check(ref_req == 1'b0, "R9", "no request inside period", ref_req, 0);
    end
    @(negedge clk);
    check(ref_req == 1'b1, "R9", "request at 5N", ref_req, 1);
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    reg_write(2'd0, 16'd1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(ref_req == 1'b0, "R9", "timer stopped in non-zero mode", ref_req, 0);
    end

    // R9: count 0 disables the timer
    reg_write(2'd1, 16'd0);
    reg_write(2'd0, 16'd0);
    host_write(32'h0000_0000, 0, 1'b0, 0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(ref_req == 1'b0, "R9", "timer disabled by zero count", ref_req, 0);
    end

    summary();
  end

endmodule